// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a source-synchronous serial bit stream back into parallel words. The line carries back-to-back 26-bit frames. Each frame opens with a two-bit boundary marker and then carries 24 payload bits. The receiver runs on the serial bit clock. It hunts through the stream for the marker and confirms it over several frames before it trusts the alignment. Once it is aligned, it hands out each finished word on a 24-bit parallel bus. A word clock that goes low for half a frame marks each new word.

The default build targets a link where the two lanes just below the top of the word are dedicated inputs at the far end. In that build the two highest received payload bits are thrown away. The two payload bits beneath them are moved up onto the two highest outputs. An enable input tells the block whether the device is currently acting as the receiver. When the enable drops, framing stops at once and the word clock is forced high. The parallel bus keeps its last word until a new aligned word replaces it.

The alignment engine has four states:

- `FR_HUNT` searches every bit for the marker.
- `FR_CONFIRM` counts consecutive frames that show the marker where it is expected.
- `FR_LOCKED` means alignment is trusted.
- `FR_COAST` means the marker was missed on the last frame but alignment is still held.

Alignment transitions:

- Hunt to confirm when the marker is seen.
- Confirm to locked on the third consecutive good marker.
- Confirm to hunt on any miss.
- Locked to coast on a miss.
- Coast to locked on a good marker.
- Coast to hunt on the second consecutive miss.
- Any state to hunt while disabled.

The word-clock stage has two states, `WC_IDLE` and `WC_STROBE`:

- Idle to strobe when an aligned frame completes.
- Strobe to idle once its 13-cycle count expires or when the block is disabled.

Top module: `sframe_rx`

## Requirements
- R1: After reset the parallel bus reads zero, `locked` is low and `wclk` is high.
- R2: A frame is the marker bit 1, then the marker bit 0, then 24 payload bits. `locked` rises during the third consecutive frame whose marker sits at the expected place. That third frame's payload is the first word presented.
- R3: Payload bits arrive least significant first: the first payload bit after the marker lands on `pdata[0]`, and payload bits 0 to 19 appear unchanged on `pdata[19:0]`.
- R4: With the dedicated-lane option set (the default), received payload bits 22 and 23 are discarded. Payload bit 20 appears on `pdata[22]`, payload bit 21 appears on `pdata[23]`, and `pdata[21:20]` read zero.
- R5: `wclk` falls on the clock edge that samples the last payload bit of an aligned frame. It stays low for 13 bit-clock cycles and then returns high.
- R6: `pdata` changes only when a frame completes while aligned (locked or coasting). At all other times it holds its value.
- R7: A single missing marker keeps `locked` high, and that frame's word is still presented. Two consecutive misses drop `locked`. The bus then holds its last word until the receiver has aligned again over three frames.
- R8: While `rx_en` is low, `wclk` is high and `locked` is low without waiting for a clock edge. `pdata` holds, incoming frames are ignored, and alignment starts again from hunting once the block is re-enabled.
- R9: Asserting reset while aligned clears `pdata` and `locked` at once. The next frame alone does not restore alignment.
- R10: A marker position holding any value other than 1 followed by 0 counts as a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; one payload or marker bit is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | High while the device acts as the receiver |
| sdata | input | 1 | Serial data bit |
| pdata | output | 24 | Recovered parallel word, held between updates |
| wclk | output | 1 | Word clock; low for half a frame after each new word, high when idle or disabled |
| locked | output | 1 | High while frame alignment is trusted |

## Verification
The assertions assume that `sdata` is stable around each rising bit-clock edge. They also assume that `rx_en` changes only between frames and is never toggled in the middle of a marker check. The bench drives every input on the falling edge and toggles the enable only at frame boundaries. It builds every frame bit by bit, so the marker position is always exactly where the test intends. Deliberate marker errors are injected as whole frames with a wrong pair in the marker position. The bench also picks the payload that follows a lost alignment so that no accidental 1-then-0 pair can start a false hunt before the intended marker.

// File: rtl/sframe_rx_pkg.sv
package sframe_rx_pkg;

    // Boundary marker: two bits, sent first in every frame.
    localparam int          BND_W       = 2;
    localparam logic [1:0]  BND_PATTERN = 2'b10;

    // Alignment engine states.
    typedef enum logic [1:0] {
        FR_HUNT    = 2'd0,
        FR_CONFIRM = 2'd1,
        FR_LOCKED  = 2'd2,
        FR_COAST   = 2'd3
    } frm_state_e;

    // Word clock strobe states.
    typedef enum logic {
        WC_IDLE   = 1'b0,
        WC_STROBE = 1'b1
    } wclk_state_e;

endpackage

// File: rtl/sframe_rx_align.sv
module sframe_rx_align
    import sframe_rx_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int LOCK_HITS  = 3,
    parameter int MISS_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic sdata,
    output logic word_done,
    output logic locked
);

    localparam int FRAME_LEN = DATA_W + BND_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int HIT_W     = $clog2(LOCK_HITS + 1);
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1);

    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0]  POS_CHECK = POS_W'(BND_W - 1);
    localparam logic [POS_W-1:0]  POS_DATA0 = POS_W'(BND_W);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    frm_state_e         state_q, state_d;
    logic [POS_W-1:0]   pos_q, pos_d, pos_inc;
    logic [HIT_W-1:0]   hits_q, hits_d;
    logic [MISS_W-1:0]  miss_q, miss_d;
    logic               prev_q;
    logic               bnd_hit;
    logic               at_check;
    logic               aligned;

    assign bnd_hit  = ({prev_q, sdata} == BND_PATTERN);
    assign at_check = (pos_q == POS_CHECK);
    assign pos_inc  = (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        hits_d  = hits_q;
        miss_d  = miss_q;
        unique case (state_q)
            FR_HUNT: begin
                pos_d = '0;
                if (bnd_hit) begin
                    pos_d   = POS_DATA0;
                    hits_d  = HIT_W'(1);
                    miss_d  = '0;
                    state_d = (LOCK_HITS <= 1) ? FR_LOCKED : FR_CONFIRM;
                end
            end
            FR_CONFIRM: begin
                pos_d = pos_inc;
                if (at_check) begin
                    if (bnd_hit) begin
                        if (hits_q == HIT_LAST) begin
                            state_d = FR_LOCKED;
                        end else begin
                            hits_d = hits_q + HIT_W'(1);
                        end
                    end else begin
                        state_d = FR_HUNT;
                        pos_d   = '0;
                    end
                end
            end
            FR_LOCKED: begin
                pos_d = pos_inc;
                if (at_check && !bnd_hit) begin
                    if (MISS_LIMIT <= 1) begin
                        state_d = FR_HUNT;
                        pos_d   = '0;
                    end else begin
                        state_d = FR_COAST;
                        miss_d  = MISS_W'(1);
                    end
                end
            end
            FR_COAST: begin
                pos_d = pos_inc;
                if (at_check) begin
                    if (bnd_hit) begin
                        state_d = FR_LOCKED;
                        miss_d  = '0;
                    end else if (miss_q == MISS_LAST) begin
                        state_d = FR_HUNT;
                        pos_d   = '0;
                    end else begin
                        miss_d = miss_q + MISS_W'(1);
                    end
                end
            end
            default: begin
                state_d = FR_HUNT;
                pos_d   = '0;
            end
        endcase
        if (!rx_en) begin
            state_d = FR_HUNT;
            pos_d   = '0;
            hits_d  = '0;
            miss_d  = '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_HUNT;
            pos_q   <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            hits_q  <= hits_d;
            miss_q  <= miss_d;
            prev_q  <= rx_en ? sdata : 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        aligned   = (state_q == FR_LOCKED) || (state_q == FR_COAST);
        locked    = rx_en && aligned;
        word_done = rx_en && aligned && (pos_q == POS_LAST);
    end

    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_LAST);

    p_no_lock_from_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_HUNT && LOCK_HITS > 1) |=> (state_q != FR_LOCKED));

    p_single_miss_coasts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && state_q == FR_LOCKED && at_check && !bnd_hit && MISS_LIMIT > 1)
        |=> (state_q == FR_COAST));

    p_double_miss_hunts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_COAST && at_check && !bnd_hit && miss_q == MISS_LAST)
        |=> (state_q == FR_HUNT));

    p_bad_marker_leaves_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_LOCKED && at_check && sdata == prev_q)
        |=> (state_q != FR_LOCKED));

    p_disable_hunts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == FR_HUNT));

endmodule

// File: rtl/sframe_rx_shift.sv
module sframe_rx_shift #(
    parameter int DATA_W       = 24,
    parameter int DEDICATED_IO = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sdata,
    output logic [DATA_W-1:0] word
);

    localparam int SR_W = DATA_W - 1;

    logic [SR_W-1:0]   sr_q;
    logic [DATA_W-1:0] assembled;

    // LSB-first: new bits enter at the top and walk down.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (rx_en) begin
            sr_q <= {sdata, sr_q[SR_W-1:1]};
        end
    end

    // Complete word while the final payload bit is on the line.
    assign assembled = {sdata, sr_q};

    generate
        if (DEDICATED_IO != 0) begin : g_dedicated
            logic unused_rsv;
            assign word = {assembled[DATA_W-3:DATA_W-4], 2'b00,
                           assembled[DATA_W-5:0]};
            assign unused_rsv = ^assembled[DATA_W-1:DATA_W-2];
        end else begin : g_full
            assign word = assembled;
        end
    endgenerate

endmodule

// File: rtl/sframe_rx_present.sv
module sframe_rx_present
    import sframe_rx_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int PULSE_LEN = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] pdata,
    output logic              wclk
);

    localparam int              CNT_W      = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

    wclk_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!rx_en) begin
            state_d = WC_IDLE;
            cnt_d   = '0;
        end else if (word_done) begin
            state_d = WC_STROBE;
            cnt_d   = PULSE_LAST;
        end else begin
            unique case (state_q)
                WC_IDLE: begin
                    cnt_d = '0;
                end
                WC_STROBE: begin
                    if (cnt_q == '0) begin
                        state_d = WC_IDLE;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: state_d = WC_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: the word register holds across turnaround.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdata <= '0;
        end else if (word_done) begin
            pdata <= word_in;
        end
    end

    assign wclk = !(rx_en && state_q == WC_STROBE);

    p_hold_between_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(pdata));

    p_strobe_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (state_q == WC_STROBE));

    p_strobe_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && state_q == WC_STROBE && cnt_q != '0) |=> (state_q == WC_STROBE));

    p_strobe_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WC_STROBE && cnt_q == '0 && !word_done) |=> (state_q == WC_IDLE));

endmodule

// File: rtl/sframe_rx.sv
module sframe_rx
    import sframe_rx_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int LOCK_HITS    = 3,
    parameter int MISS_LIMIT   = 2,
    parameter int DEDICATED_IO = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sdata,
    output logic [DATA_W-1:0] pdata,
    output logic              wclk,
    output logic              locked
);

    localparam int FRAME_LEN = DATA_W + BND_W;
    localparam int PULSE_LEN = FRAME_LEN / 2;

    logic              word_done;
    logic [DATA_W-1:0] word;

    sframe_rx_align #(
        .DATA_W    (DATA_W),
        .LOCK_HITS (LOCK_HITS),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .sdata    (sdata),
        .word_done(word_done),
        .locked   (locked)
    );

    sframe_rx_shift #(
        .DATA_W      (DATA_W),
        .DEDICATED_IO(DEDICATED_IO)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .rx_en(rx_en),
        .sdata(sdata),
        .word (word)
    );

    sframe_rx_present #(
        .DATA_W   (DATA_W),
        .PULSE_LEN(PULSE_LEN)
    ) u_present (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .word_done(word_done),
        .word_in  (word),
        .pdata    (pdata),
        .wclk     (wclk)
    );

    p_disable_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !locked);

    p_word_only_when_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> locked);

endmodule

// File: tb/sframe_rx_bench.sv
module sframe_rx_bench;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b1;
    logic        sdata = 1'b0;
    logic [23:0] pdata;
    logic        wclk;
    logic        locked;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic        wc12, wc13;
    logic [23:0] p13;

    // {payload, expected pdata}
    localparam logic [47:0] VEC [8] = '{
        {24'h000001, 24'h000001},
        {24'h800000, 24'h000000},
        {24'h300000, 24'hC00000},
        {24'h155555, 24'h455555},
        {24'hAAAAAA, 24'h8AAAAA},
        {24'h0FFFFF, 24'h0FFFFF},
        {24'hC3A5F0, 24'h03A5F0},
        {24'h7E1234, 24'hCE1234}
    };

    always #2 clk = ~clk;

    sframe_rx u_sframe_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_en (rx_en),
        .sdata (sdata),
        .pdata (pdata),
        .wclk  (wclk),
        .locked(locked)
    );

    function automatic logic [23:0] exp_map(input logic [23:0] d);
        logic [23:0] r;
        r        = d;
        r[21:20] = 2'b00;
        r[23:22] = d[21:20];
        return r;
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends on a falling edge; one bit per clock period.
    task automatic send_frame(input logic [23:0] d, input logic b0, input logic b1);
        sdata = b0; @(negedge clk);
        sdata = b1; @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            sdata = d[i];
            @(negedge clk);
            if (i == 9)  wc12 = wclk;
            if (i == 10) begin wc13 = wclk; p13 = pdata; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] prev_exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pdata", pdata, 24'h0);
        chk("R1 locked", {23'b0, locked}, 24'h0);
        chk("R1 wclk", {23'b0, wclk}, 24'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 lock needs three good frames; R6 no update before lock
        send_frame(24'h123456, 1'b1, 1'b0);
        chk("R2 locked after frame 1", {23'b0, locked}, 24'h0);
        send_frame(24'h654321, 1'b1, 1'b0);
        chk("R2 locked after frame 2", {23'b0, locked}, 24'h0);
        chk("R6 pdata before lock", pdata, 24'h0);
        send_frame(24'h0ABCDE, 1'b1, 1'b0);
        chk("R2 locked after frame 3", {23'b0, locked}, 24'h1);
        chk("R2 first word", pdata, exp_map(24'h0ABCDE));
        chk("R5 wclk falls", {23'b0, wclk}, 24'h0);
        prev_exp = exp_map(24'h0ABCDE);

        // R3/R4/R5/R6 vector walk
        for (int v = 0; v < 8; v++) begin
            send_frame(VEC[v][47:24], 1'b1, 1'b0);
            chk("R5 wclk low at 12 cycles", {23'b0, wc12}, 24'h0);
            chk("R5 wclk high at 13 cycles", {23'b0, wc13}, 24'h1);
            chk("R6 pdata held mid-frame", p13, prev_exp);
            chk("R3 R4 word", pdata, VEC[v][23:0]);
            chk("R5 wclk low at word", {23'b0, wclk}, 24'h0);
            chk("R2 stays locked", {23'b0, locked}, 24'h1);
            prev_exp = VEC[v][23:0];
        end

        // R10 marker 11 is a miss; R7 single miss keeps lock
        send_frame(24'h111111, 1'b1, 1'b1);
        chk("R7 locked after one miss", {23'b0, locked}, 24'h1);
        chk("R7 word during coast", pdata, exp_map(24'h111111));
        send_frame(24'h222222, 1'b1, 1'b0);
        chk("R7 relocked", {23'b0, locked}, 24'h1);
        chk("R7 word after recovery", pdata, exp_map(24'h222222));
        send_frame(24'h333333, 1'b0, 1'b1);
        chk("R10 marker 01 is a miss", {23'b0, locked}, 24'h1);
        send_frame(24'hFFFFFF, 1'b0, 1'b0);
        chk("R7 two misses drop lock", {23'b0, locked}, 24'h0);
        chk("R7 pdata held after loss", pdata, exp_map(24'h333333));
        send_frame(24'h444444, 1'b1, 1'b0);
        chk("R7 hold during reconfirm", pdata, exp_map(24'h333333));
        send_frame(24'h555555, 1'b1, 1'b0);
        chk("R7 not yet locked", {23'b0, locked}, 24'h0);
        send_frame(24'h666666, 1'b1, 1'b0);
        chk("R7 relock", {23'b0, locked}, 24'h1);
        chk("R7 word after relock", pdata, exp_map(24'h666666));

        // R8 disable
        rx_en = 1'b0;
        #1;
        chk("R8 wclk high when disabled", {23'b0, wclk}, 24'h1);
        chk("R8 locked low when disabled", {23'b0, locked}, 24'h0);
        @(negedge clk);
        send_frame(24'h777777, 1'b1, 1'b0);
        send_frame(24'h888888, 1'b1, 1'b0);
        chk("R8 pdata held while disabled", pdata, exp_map(24'h666666));
        chk("R8 wclk high while disabled", {23'b0, wclk}, 24'h1);
        rx_en = 1'b1;
        send_frame(24'h0F0F0F, 1'b1, 1'b0);
        send_frame(24'h1E1E1E, 1'b1, 1'b0);
        chk("R8 re-hunt needed", {23'b0, locked}, 24'h0);
        chk("R8 pdata held during re-hunt", pdata, exp_map(24'h666666));
        send_frame(24'h2D2D2D, 1'b1, 1'b0);
        chk("R8 locked after re-enable", {23'b0, locked}, 24'h1);
        chk("R8 new word overwrites", pdata, exp_map(24'h2D2D2D));

        // R9 reset while locked
        rst_n = 1'b0;
        #1;
        chk("R9 pdata cleared", pdata, 24'h0);
        chk("R9 locked cleared", {23'b0, locked}, 24'h0);
        chk("R9 wclk high", {23'b0, wclk}, 24'h1);
        @(negedge clk);
        rst_n = 1'b1;
        sdata = 1'b0;
        @(negedge clk);
        send_frame(24'h3C3C3C, 1'b1, 1'b0);
        chk("R9 no lock after one frame", {23'b0, locked}, 24'h0);
        chk("R9 pdata still zero", pdata, 24'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule